// File: doc/BRIEF.md
# Packed SIMD Saturating Add/Subtract Unit

This block is a lane-parallel integer adder/subtractor for a 128-bit vector datapath. On each valid strobe it takes two 128-bit operands and splits them into independent lanes of 8, 16 or 32 bits. It then adds or subtracts every lane pair, as signed or unsigned numbers, and produces one of three kinds of result. Wraparound mode keeps the low bits. Clamped mode limits each lane to its representable range. Carry mode writes each word lane's carry or no-borrow condition as a 0/1 value.

The result appears on a registered output one clock after the strobe. A sticky status bit records that at least one lane was clamped. Software clears it with a dedicated input. Floating-point lanes, instruction decode and register-file access belong to other blocks.

Top module: `simd_addsub_unit`

## Requirements
- R1: `elem_size` selects the lane width: 0 gives 16 lanes of 8 bits, 1 gives 8 lanes of 16 bits, 2 gives 4 lanes of 32 bits. Lane 0 occupies the most significant bits of the bus. Each lane's result depends only on that lane's operands.
- R2: With `res_mode` = 0 (wraparound), each lane holds the low lane-width bits of a+b (`op_sub`=0) or a-b (`op_sub`=1), and the status bit is not set.
- R3: With `res_mode` = 1 (clamped), `is_signed`=0 and `op_sub`=0, a lane whose true sum exceeds the lane maximum becomes all ones.
- R4: With `res_mode` = 1, `is_signed`=0 and `op_sub`=1, a lane whose true difference is negative becomes zero.
- R5: With `res_mode` = 1 and `is_signed`=1, a lane whose true signed sum or difference exceeds the range becomes the largest positive value, and one below the range becomes the most negative value. This holds when b is the most negative value.
- R6: With `res_mode` = 2 (carry) and `elem_size` = 2, each word lane is 1 when the unsigned sum overflows 32 bits (add), or when a >= b unsigned (subtract), and 0 otherwise. `is_signed` has no effect in this mode.
- R7: With `res_mode` = 2 and a byte or halfword size, the result is all zeros and the status bit is unchanged.
- R8: A valid clamped operation in which any lane is clamped sets `sat_sticky`. Any other operation leaves the bit unchanged.
- R9: `sat_clear` clears `sat_sticky` on the next clock. When the same clock also carries a clamping operation, the bit stays set.
- R10: `out_valid` equals `in_valid` delayed by one clock. `result` loads only on a valid strobe and otherwise holds. Synchronous reset zeros `result`, `out_valid` and `sat_sticky`.
- R11: The reserved codes `elem_size` = 3 and `res_mode` = 3 give an all-zero result and leave the status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 0 add, 1 subtract |
| elem_size | input | 2 | Lane width code |
| is_signed | input | 1 | Signed lane arithmetic for clamped mode |
| res_mode | input | 2 | 0 wrap, 1 clamp, 2 carry, 3 reserved |
| opnd_a | input | 128 | First operand |
| opnd_b | input | 128 | Second operand |
| sat_clear | input | 1 | Clears the sticky status bit |
| out_valid | output | 1 | Result valid, one clock after strobe |
| result | output | 128 | Registered lane results |
| sat_sticky | output | 1 | Sticky clamp status |

## Verification
Every stage of this block is combinational apart from the output register and the sticky bit. A wrong lane boundary, a wrong overflow test or a wrong clamp value therefore shows on `result` in the cycle right after the strobe that exposed it. The sticky bit holds memory across operations. A missed set or a missed clear shows at once and stays visible until the next clear or set. For that reason the bench compares all three outputs against its model on every clock, and does not wait for the end of a sequence.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;
  localparam int VEC_W = 128;
  localparam int NUM_SIZES = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } elem_size_e;

  typedef enum logic [1:0] {
    RM_WRAP  = 2'd0,
    RM_CLAMP = 2'd1,
    RM_CARRY = 2'd2,
    RM_RSVD  = 2'd3
  } res_mode_e;

  typedef struct packed {
    logic sub;
    logic sgn;
  } arith_ctl_t;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  simd_addsub_pkg::arith_ctl_t ctl,
  output logic [W-1:0] wrap,
  output logic [W-1:0] clamp,
  output logic         cout,
  output logic         sat
);
  logic [W-1:0] b_eff;
  logic [W:0]   ext;
  logic         s_ovf;
  logic         u_ovf;

  // subtraction is a + ~b + 1; carry out then means "no borrow"
  assign b_eff = ctl.sub ? ~b : b;
  assign ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ctl.sub};
  assign wrap  = ext[W-1:0];
  assign cout  = ext[W];

  assign s_ovf = (a[W-1] == b_eff[W-1]) && (wrap[W-1] != a[W-1]);
  assign u_ovf = ctl.sub ? ~cout : cout;
  assign sat   = ctl.sgn ? s_ovf : u_ovf;

  always_comb begin
    if (!sat) begin
      clamp = wrap;
    end else if (ctl.sgn) begin
      clamp = wrap[W-1] ? {1'b0, {(W-1){1'b1}}} : {1'b1, {(W-1){1'b0}}};
    end else begin
      clamp = ctl.sub ? {W{1'b0}} : {W{1'b1}};
    end
  end
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array #(
  parameter int VEC = 128,
  parameter int W   = 8
) (
  input  logic [VEC-1:0] a,
  input  logic [VEC-1:0] b,
  input  simd_addsub_pkg::arith_ctl_t ctl,
  output logic [VEC-1:0] wrap_v,
  output logic [VEC-1:0] clamp_v,
  output logic [VEC-1:0] carry_v,
  output logic           sat_any
);
  localparam int N = VEC / W;

  logic [N-1:0] sat_l;

  for (genvar i = 0; i < N; i++) begin : g_lane
    localparam int HI = VEC - 1 - i * W;  // lane 0 at the top
    logic cout_l;

    simd_lane #(.W(W)) u_lane (
      .a     (a[HI -: W]),
      .b     (b[HI -: W]),
      .ctl   (ctl),
      .wrap  (wrap_v[HI -: W]),
      .clamp (clamp_v[HI -: W]),
      .cout  (cout_l),
      .sat   (sat_l[i])
    );

    assign carry_v[HI -: W] = {{(W-1){1'b0}}, cout_l};
  end

  assign sat_any = |sat_l;
endmodule

// File: rtl/simd_sat_sticky.sv
module simd_sat_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (set) begin
      q <= 1'b1;
    end else if (clr) begin
      q <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
  import simd_addsub_pkg::*;
#(
  parameter int VEC   = VEC_W,
  parameter int MIN_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           op_sub,
  input  logic [1:0]     elem_size,
  input  logic           is_signed,
  input  logic [1:0]     res_mode,
  input  logic [VEC-1:0] opnd_a,
  input  logic [VEC-1:0] opnd_b,
  input  logic           sat_clear,
  output logic           out_valid,
  output logic [VEC-1:0] result,
  output logic           sat_sticky
);
  arith_ctl_t ctl;
  assign ctl.sub = op_sub;
  assign ctl.sgn = is_signed;

  logic [VEC-1:0] wrap_s  [NUM_SIZES];
  logic [VEC-1:0] clamp_s [NUM_SIZES];
  logic [VEC-1:0] carry_s [NUM_SIZES];
  logic [NUM_SIZES-1:0] sat_s;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    simd_lane_array #(.VEC(VEC), .W(MIN_W << g)) u_arr (
      .a       (opnd_a),
      .b       (opnd_b),
      .ctl     (ctl),
      .wrap_v  (wrap_s[g]),
      .clamp_v (clamp_s[g]),
      .carry_v (carry_s[g]),
      .sat_any (sat_s[g])
    );
  end

  logic [VEC-1:0] res_d;
  logic           sat_hit;
  logic           size_ok;

  assign size_ok = (elem_size != SZ_RSVD);

  always_comb begin
    res_d = '0;
    if (size_ok) begin
      unique case (res_mode)
        RM_WRAP:  res_d = wrap_s[elem_size];
        RM_CLAMP: res_d = clamp_s[elem_size];
        RM_CARRY: res_d = (elem_size == SZ_WORD) ? carry_s[NUM_SIZES-1] : '0;
        default:  res_d = '0;
      endcase
    end
  end

  assign sat_hit = in_valid && size_ok && (res_mode == RM_CLAMP) && sat_s[elem_size];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_d;
      end
    end
  end

  simd_sat_sticky u_sticky (
    .clk (clk),
    .rst (rst),
    .set (sat_hit),
    .clr (sat_clear),
    .q   (sat_sticky)
  );
endmodule

// File: rtl/simd_addsub_checker.sv
module simd_addsub_checker #(
  parameter int VEC = 128
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [1:0]     elem_size,
  input logic [1:0]     res_mode,
  input logic           sat_clear,
  input logic           out_valid,
  input logic [VEC-1:0] result,
  input logic           sat_sticky
);
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r10_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  a_r7_carry_narrow_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && res_mode == 2'd2 && elem_size != 2'd2) |=> (result == '0));
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (res_mode == 2'd3 || elem_size == 2'd3)) |=> (result == '0));
  a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_sticky) |-> $past(in_valid && res_mode == 2'd1));
  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    (sat_sticky && !sat_clear) |=> sat_sticky);
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (sat_clear && !(in_valid && res_mode == 2'd1)) |=> !sat_sticky);
  a_r2_modulo_no_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && res_mode != 2'd1 && !sat_clear) |=> $stable(sat_sticky));
endmodule

bind simd_addsub_unit simd_addsub_checker #(.VEC(VEC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .elem_size  (elem_size),
  .res_mode   (res_mode),
  .sat_clear  (sat_clear),
  .out_valid  (out_valid),
  .result     (result),
  .sat_sticky (sat_sticky)
);

// File: tb/simd_addsub_unit_tb_top.sv
module simd_addsub_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         op_sub = 1'b0;
  logic [1:0]   elem_size = 2'd0;
  logic         is_signed = 1'b0;
  logic [1:0]   res_mode = 2'd0;
  logic [127:0] opnd_a = '0;
  logic [127:0] opnd_b = '0;
  logic         sat_clear = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         sat_sticky;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    armed = 1'b0;
  string cur_req = "R10";
  string exp_tag = "R10";

  logic [127:0] exp_res = '0;
  logic         exp_vld = 1'b0;
  logic         exp_sticky = 1'b0;

  always #5 clk = ~clk;

  simd_addsub_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .elem_size(elem_size), .is_signed(is_signed), .res_mode(res_mode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_clear(sat_clear),
    .out_valid(out_valid), .result(result), .sat_sticky(sat_sticky)
  );

  function automatic void ref_op(input logic [127:0] a, input logic [127:0] b,
                                 input logic sub, input logic sgn,
                                 input logic [1:0] sz, input logic [1:0] md,
                                 output logic [127:0] r, output logic sat);
    longint w, m, ua, ub, xa, xb, t, v, lo, hi;
    logic [127:0] ta, tb;
    r = '0;
    sat = 1'b0;
    if (sz == 2'd3 || md == 2'd3) return;
    if (md == 2'd2 && sz != 2'd2) return;
    w = longint'(8) << sz;
    m = (longint'(1) << w) - 1;
    for (int i = 0; i < 128 / int'(w); i++) begin
      int sh = 128 - (i + 1) * int'(w);
      ta = a >> sh;
      tb = b >> sh;
      ua = longint'(ta[63:0]) & m;
      ub = longint'(tb[63:0]) & m;
      xa = ua;
      xb = ub;
      if (sgn) begin
        if (ua >= (longint'(1) << (w - 1))) xa = ua - (longint'(1) << w);
        if (ub >= (longint'(1) << (w - 1))) xb = ub - (longint'(1) << w);
      end
      t = sub ? xa - xb : xa + xb;
      case (md)
        2'd0: v = t;
        2'd1: begin
          lo = sgn ? -(longint'(1) << (w - 1)) : 0;
          hi = sgn ? (longint'(1) << (w - 1)) - 1 : m;
          if (t > hi) begin v = hi; sat = 1'b1; end
          else if (t < lo) begin v = lo; sat = 1'b1; end
          else v = t;
        end
        default: v = sub ? longint'(ua >= ub) : longint'((ua + ub) > m);
      endcase
      r = r | ((128'(v & m)) << sh);
    end
  endfunction

  // reference model, one step per clock
  always @(posedge clk) begin
    logic [127:0] r;
    logic s;
    if (rst) begin
      exp_vld = 1'b0;
      exp_res = '0;
      exp_sticky = 1'b0;
    end else begin
      ref_op(opnd_a, opnd_b, op_sub, is_signed, elem_size, res_mode, r, s);
      exp_vld = in_valid;
      if (in_valid) exp_res = r;
      if (in_valid && s) exp_sticky = 1'b1;
      else if (sat_clear) exp_sticky = 1'b0;
    end
    exp_tag = cur_req;
    armed = 1'b1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (result !== exp_res || out_valid !== exp_vld || sat_sticky !== exp_sticky) begin
        errors++;
        $display("FAIL %s result=%h valid=%b sticky=%b expected result=%h valid=%b sticky=%b",
                 exp_tag, result, out_valid, sat_sticky, exp_res, exp_vld, exp_sticky);
      end
    end
  end

  task automatic op(input string tag, input logic [127:0] a, input logic [127:0] b,
                    input logic sub, input logic sgn, input logic [1:0] sz,
                    input logic [1:0] md, input logic clr);
    @(negedge clk);
    cur_req = tag;
    in_valid = 1'b1; opnd_a = a; opnd_b = b; op_sub = sub; is_signed = sgn;
    elem_size = sz; res_mode = md; sat_clear = clr;
  endtask

  task automatic idle(input string tag, input logic clr);
    @(negedge clk);
    cur_req = tag;
    in_valid = 1'b0; sat_clear = clr;
    opnd_a = ~opnd_a;
  endtask

  task automatic expect_direct(input string tag, input logic [127:0] exp_r, input logic exp_s);
    @(negedge clk);
    #1;
    checks++;
    if (result !== exp_r || sat_sticky !== exp_s) begin
      errors++;
      $display("FAIL %s result=%h sticky=%b expected result=%h sticky=%b",
               tag, result, sat_sticky, exp_r, exp_s);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (result !== '0 || out_valid !== 1'b0 || sat_sticky !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset result=%h valid=%b sticky=%b expected 0 0 0",
               result, out_valid, sat_sticky);
    end
    rst = 1'b0;

    // R1 lane placement, R2 wraparound
    op("R1", 128'h00010203_04050607_08090A0B_0C0D0E0F, {16{8'h01}}, 0, 0, 2'd0, 2'd0, 0);
    op("R2", {16{8'hF0}}, {16{8'h20}}, 0, 0, 2'd0, 2'd0, 0);
    op("R2", {8{16'h0001}}, {8{16'h0002}}, 1, 0, 2'd1, 2'd0, 0);
    op("R2", {4{32'hFFFF_FFFF}}, {4{32'h0000_0002}}, 0, 1, 2'd2, 2'd0, 0);
    expect_direct("R2", {4{32'h0000_0001}}, 1'b0);
    // R3 / R4 unsigned clamp
    op("R3", {16{8'hF0}}, {16{8'h20}}, 0, 0, 2'd0, 2'd1, 0);
    expect_direct("R3", {16{8'hFF}}, 1'b1);
    op("R9", '0, '0, 0, 0, 2'd0, 2'd0, 1);
    op("R4", {8{16'h0010}}, {8{16'h0020}}, 1, 0, 2'd1, 2'd1, 0);
    expect_direct("R4", '0, 1'b1);
    // R5 signed clamp
    op("R5", {16{8'h7F}}, {16{8'h01}}, 0, 1, 2'd0, 2'd1, 1);
    op("R5", {16{8'h80}}, {16{8'hFF}}, 0, 1, 2'd0, 2'd1, 0);
    op("R5", {16{8'h80}}, {16{8'h01}}, 1, 1, 2'd0, 2'd1, 0);
    op("R5", {4{32'h0}}, {4{32'h8000_0000}}, 1, 1, 2'd2, 2'd1, 0);
    expect_direct("R5", {4{32'h7FFF_FFFF}}, 1'b1);
    op("R5", {4{32'h7FFF_0000}}, {4{32'h0000_1000}}, 0, 1, 2'd2, 2'd1, 1);
    // R6 carry
    op("R6", {32'hFFFF_FFFF, 32'h1, 32'h8000_0000, 32'h0},
             {32'h1, 32'h1, 32'h8000_0000, 32'h0}, 0, 0, 2'd2, 2'd2, 0);
    op("R6", {32'h5, 32'h5, 32'h4, 32'h0},
             {32'h5, 32'h4, 32'h5, 32'h1}, 1, 1, 2'd2, 2'd2, 0);
    expect_direct("R6", {32'h1, 32'h1, 32'h0, 32'h0}, 1'b0);
    // R7 carry on narrow lanes, R11 reserved codes
    op("R8", {16{8'hFF}}, {16{8'hFF}}, 0, 0, 2'd0, 2'd1, 0);
    op("R7", {16{8'hFF}}, {16{8'hFF}}, 0, 0, 2'd0, 2'd2, 0);
    op("R7", {8{16'hFFFF}}, {8{16'hFFFF}}, 0, 0, 2'd1, 2'd2, 0);
    expect_direct("R7", '0, 1'b1);
    op("R11", {16{8'hFF}}, {16{8'h01}}, 0, 0, 2'd3, 2'd1, 0);
    op("R11", {16{8'hFF}}, {16{8'h01}}, 0, 0, 2'd0, 2'd3, 0);
    // R8 non-saturating op keeps bit; R9 clear and set together
    op("R8", {16{8'h01}}, {16{8'h01}}, 0, 0, 2'd0, 2'd1, 0);
    op("R9", {16{8'hFF}}, {16{8'h01}}, 0, 0, 2'd0, 2'd1, 1);
    expect_direct("R9", {16{8'hFF}}, 1'b1);
    idle("R9", 1);
    // R10 hold while idle
    idle("R10", 0);
    idle("R10", 0);
    // R1 randomized patterns
    for (int k = 0; k < 400; k++) begin
      logic [127:0] ra, rb;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      if (k % 7 == 3) idle("R10", k % 3 == 0);
      else op("R1", ra, rb, 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom),
              ($urandom % 5) == 0);
    end
    idle("R10", 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule